// File: doc/BRIEF.md
# Synchronized Glitch-Free Clock Output Gate

This block takes two reference clocks, picks one with a static select input, and drives the picked clock onto ten complementary output pairs. A stop request input may change at any moment, with no timing relation to either clock. The request is resynchronized to the picked clock, and the output gate opens or closes only while that clock is low. Every high phase that reaches the outputs is therefore a full half period: no pulse is ever cut short and no runt pulse appears.

The gate is a two-state machine clocked on the falling edge of the picked clock. In state `GATE_OPEN` the outputs follow the clock. In state `GATE_SHUT` every true output is low and every complement is high. The transition *close* (`GATE_OPEN` to `GATE_SHUT`) is taken at a falling edge when the synchronized request is high. The transition *reopen* (`GATE_SHUT` to `GATE_OPEN`) is taken at a falling edge when the synchronized request is low.

The asynchronous reset clears the synchronizer and forces `GATE_OPEN`, so the outputs run as soon as reset is released. The select input is expected to change only while reset is held.

Top module: `refclk_gate_fanout`

## Requirements
- R1: With `sel_b` = 0 the outputs carry `ref_a`; with `sel_b` = 1 they carry `ref_b`. The output period equals the period of the picked clock.
- R2: While the stop request is low and has been low through the synchronizer, all ten `out_p` bits equal the picked clock.
- R3: While the gate is shut, every `out_p` bit is 0 and every `out_n` bit is 1.
- R4: The stop request may change at any offset within the clock period, including pulses shorter than one period. Every output high phase still lasts exactly half the picked clock period.
- R5: The gate changes state only while the picked clock is low, so a high phase already in progress is never truncated.
- R6: The outputs stop no earlier than 2.5 and no later than 3.5 picked-clock periods after the stop request rises. The stop time is taken as the falling edge that ends the last high phase.
- R7: The first output rising edge after the stop request falls comes no earlier than 3 and no later than 4 picked-clock periods after the fall.
- R8: For each of the ten pairs, `out_n` is always the exact inverse of `out_p`.
- R9: While `rst_n` is low, the gate is forced to `GATE_OPEN` whatever the stop request, so the outputs toggle. After release the request takes effect with the normal latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_a | input | 1 | First reference clock, routed to the outputs when `sel_b` is 0 |
| ref_b | input | 1 | Second reference clock, routed to the outputs when `sel_b` is 1 |
| sel_b | input | 1 | Static reference select |
| stop_req | input | 1 | Asynchronous active-high stop request |
| rst_n | input | 1 | Asynchronous active-low reset |
| out_p | output | 10 | True clock outputs, one bit per pair |
| out_n | output | 10 | Complement clock outputs, one bit per pair |

## Verification
The stop request is raised and dropped at random offsets inside the clock period on both references. This separates a design whose latency depends on where the edge lands from one that stays inside the 2.5–3.5 and 3–4 period windows. Short request pulses, narrower than one period, are applied to expose any gate that switches in the high phase; such a gate would show up as a high phase shorter than half a period. Holding the request high during reset tells a design that clears to the open state apart from one that carries a stale stop. Measuring the output period under each select setting tells the two references apart.

// File: rtl/gate_fanout_pkg.sv
package gate_fanout_pkg;
    typedef enum logic {
        GATE_OPEN = 1'b0,
        GATE_SHUT = 1'b1
    } gate_state_t;
endpackage

// File: rtl/ref_clk_pick.sv
module ref_clk_pick (
    input  logic ref_a,
    input  logic ref_b,
    input  logic sel_b,
    output logic clk_out
);
    always_comb begin
        if (sel_b) clk_out = ref_b;
        else       clk_out = ref_a;
    end
endmodule

// File: rtl/stop_sync.sv
module stop_sync #(
    parameter int STAGES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    localparam int LAST = STAGES - 1;
    logic [LAST:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[LAST-1:0], async_in};
    end

    assign sync_out = chain_q[LAST];
endmodule

// File: rtl/gate_fsm.sv
module gate_fsm
    import gate_fanout_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic stop_sync,
    output logic gate_en
);
    gate_state_t state_q, state_d;

    // next-state selection: close / reopen
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GATE_OPEN: if (stop_sync)  state_d = GATE_SHUT;
            GATE_SHUT: if (!stop_sync) state_d = GATE_OPEN;
            default:                   state_d = GATE_OPEN;
        endcase
    end

    // state register on the falling edge: changes only in the low phase
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= GATE_OPEN;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        unique case (state_q)
            GATE_OPEN: gate_en = 1'b1;
            GATE_SHUT: gate_en = 1'b0;
            default:   gate_en = 1'b0;
        endcase
    end
endmodule

// File: rtl/pair_fanout.sv
module pair_fanout #(
    parameter int N_PAIRS = 10
) (
    input  logic               clk,
    input  logic               gate_en,
    output logic [N_PAIRS-1:0] out_p,
    output logic [N_PAIRS-1:0] out_n
);
    generate
        for (genvar g = 0; g < N_PAIRS; g++) begin : g_pair
            logic gated;
            assign gated    = clk & gate_en;
            assign out_p[g] = gated;
            assign out_n[g] = ~gated;
        end
    endgenerate
endmodule

// File: rtl/refclk_gate_fanout.sv
module refclk_gate_fanout #(
    parameter int N_PAIRS     = 10,
    parameter int SYNC_STAGES = 3
) (
    input  logic               ref_a,
    input  logic               ref_b,
    input  logic               sel_b,
    input  logic               stop_req,
    input  logic               rst_n,
    output logic [N_PAIRS-1:0] out_p,
    output logic [N_PAIRS-1:0] out_n
);
    logic sel_clk;
    logic sync_q;
    logic gate_en;

    ref_clk_pick u_pick (
        .ref_a   (ref_a),
        .ref_b   (ref_b),
        .sel_b   (sel_b),
        .clk_out (sel_clk)
    );

    stop_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (sel_clk),
        .rst_n    (rst_n),
        .async_in (stop_req),
        .sync_out (sync_q)
    );

    gate_fsm u_fsm (
        .clk       (sel_clk),
        .rst_n     (rst_n),
        .stop_sync (sync_q),
        .gate_en   (gate_en)
    );

    pair_fanout #(.N_PAIRS(N_PAIRS)) u_fan (
        .clk     (sel_clk),
        .gate_en (gate_en),
        .out_p   (out_p),
        .out_n   (out_n)
    );
endmodule

// File: rtl/refclk_gate_fanout_chk.sv
module refclk_gate_fanout_chk #(
    parameter int N_PAIRS = 10
) (
    input logic               sel_clk,
    input logic               rst_n,
    input logic               sync_q,
    input logic               gate_en,
    input logic [N_PAIRS-1:0] out_p,
    input logic [N_PAIRS-1:0] out_n
);
    // R5: gate state changes only in the low phase of the picked clock
    always @(gate_en) begin
        if (rst_n) begin
            p_low_phase_switch_r5: assert (!sel_clk)
                else $error("gate changed while clock high");
        end
    end

    // R6: synchronized stop closes the gate at the next falling edge
    p_close_on_stop_r6: assert property (@(negedge sel_clk) disable iff (!rst_n)
        sync_q |=> !gate_en);

    // R7: synchronized release reopens the gate at the next falling edge
    p_reopen_on_release_r7: assert property (@(negedge sel_clk) disable iff (!rst_n)
        !sync_q |=> gate_en);

    // R2: open gate passes the high phase to every pair
    p_open_passes_r2: assert property (@(negedge sel_clk) disable iff (!rst_n)
        gate_en |-> (out_p == '1));

    // R3: shut gate holds true low and complement high
    p_shut_holds_r3: assert property (@(negedge sel_clk) disable iff (!rst_n)
        !gate_en |-> ((out_p == '0) && (out_n == '1)));

    // R8: complements invert in both phases
    p_pair_inverse_hi_r8: assert property (@(negedge sel_clk) disable iff (!rst_n)
        out_n == ~out_p);
    p_pair_inverse_lo_r8: assert property (@(posedge sel_clk) disable iff (!rst_n)
        out_n == ~out_p);
endmodule

bind refclk_gate_fanout refclk_gate_fanout_chk #(.N_PAIRS(N_PAIRS)) chk_i (
    .sel_clk (sel_clk),
    .rst_n   (rst_n),
    .sync_q  (sync_q),
    .gate_en (gate_en),
    .out_p   (out_p),
    .out_n   (out_n)
);

// File: tb/refclk_gate_fanout_tb_top.sv
`timescale 1ns/1ps
module refclk_gate_fanout_tb_top;
    localparam int  NP = 10;
    localparam real TA = 8.0;    // 125 MHz
    localparam real TB = 10.0;

    logic ref_a = 1'b0, ref_b = 1'b0, sel_b = 1'b0, stop_req = 1'b0, rst_n = 1'b1;
    logic [NP-1:0] out_p, out_n;

    refclk_gate_fanout dut_i (
        .ref_a(ref_a), .ref_b(ref_b), .sel_b(sel_b), .stop_req(stop_req),
        .rst_n(rst_n), .out_p(out_p), .out_n(out_n)
    );

    always #(TA/2) ref_a = ~ref_a;
    always #(TB/2) ref_b = ~ref_b;
    wire mclk = sel_b ? ref_b : ref_a;

    int  checks = 0, errors = 0;
    bit  cmp_en = 0, pw_en = 0, done = 0;
    real per = TA;

    task automatic chk(input bit ok, input string tag, input string what,
                       input real act, input real exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0.3f expected=%0.3f", tag, what, act, exp);
        end
    endtask

    // behavioural reference: delay line of request samples, falling-edge gate
    bit mq[$] = '{1'b0, 1'b0, 1'b0};
    bit m_open = 1'b1;
    always @(posedge mclk or negedge rst_n) begin
        if (!rst_n) mq = '{1'b0, 1'b0, 1'b0};
        else begin
            mq.push_back(stop_req);
            void'(mq.pop_front());
        end
    end
    always @(negedge mclk or negedge rst_n) begin
        if (!rst_n) m_open = 1'b1;
        else        m_open = !mq[0];
    end

    // compare on every clock, in both phases
    always @(posedge mclk) begin
        #1;
        if (cmp_en) begin
            chk(out_p == {NP{m_open}}, m_open ? "R2" : "R3", "out_p high phase",
                real'(out_p), m_open ? real'({NP{1'b1}}) : 0.0);
            chk(out_n == ~out_p, "R8", "out_n inverse", real'(out_n), real'(~out_p));
        end
    end
    always @(negedge mclk) begin
        #1;
        if (cmp_en) begin
            chk(out_p == '0, "R5", "out_p low phase", real'(out_p), 0.0);
            chk(out_n == ~out_p, "R8", "out_n inverse", real'(out_n), real'(~out_p));
        end
    end

    // pulse-width monitor on two pairs
    for (genvar g = 0; g < NP; g += 9) begin : g_pw
        real t_up;
        always @(posedge out_p[g]) t_up = $realtime;
        always @(negedge out_p[g]) begin
            if (pw_en && t_up > 0.0) begin
                real w;
                w = $realtime - t_up;
                chk((w > per/2 - 0.01) && (w < per/2 + 0.01), "R4", "high width", w, per/2);
            end
        end
    end

    task automatic do_reset(input bit sel, input bit hold);
        cmp_en = 0; pw_en = 0;
        #1.3 rst_n = 1'b0;
        stop_req = hold;
        #2 sel_b = sel;
        per = sel ? TB : TA;
        repeat (3) @(posedge mclk);
        cmp_en = 1;
        // R9: reset forces open even with stop held
        repeat (2) begin
            @(posedge mclk); #1.5;
            chk(out_p == '1, "R9", "toggling in reset", real'(out_p), real'({NP{1'b1}}));
        end
        @(negedge mclk); #(per/4);
        rst_n = 1'b1;
        repeat (2) @(posedge mclk);
        pw_en = 1;
    endtask

    task automatic check_period;
        real t1, t2;
        @(posedge out_p[3]); t1 = $realtime;
        @(posedge out_p[3]); t2 = $realtime;
        chk((t2 - t1 > per - 0.01) && (t2 - t1 < per + 0.01), "R1", "output period",
            t2 - t1, per);
    endtask

    task automatic lat_stop(input real frac);
        real t0, ts;
        ts = 0.0;
        @(posedge mclk); #(frac * per);
        t0 = $realtime; stop_req = 1'b1;
        for (int k = 0; k < 8; k++) begin
            @(posedge mclk); #0.5;
            if (out_p[0] == 1'b0) begin ts = $realtime - 0.5 - per/2; break; end
        end
        chk((ts - t0 >= 2.5*per) && (ts - t0 <= 3.5*per), "R6", "stop latency",
            ts - t0, 3.0*per);
        repeat (3) @(posedge mclk);
    endtask

    task automatic lat_start(input real frac);
        real t0, ts;
        ts = 0.0;
        @(posedge mclk); #(frac * per);
        t0 = $realtime; stop_req = 1'b0;
        for (int k = 0; k < 8; k++) begin
            @(posedge mclk); #0.5;
            if (out_p[0] == 1'b1) begin ts = $realtime - 0.5; break; end
        end
        chk((ts - t0 >= 3.0*per) && (ts - t0 <= 4.0*per), "R7", "start latency",
            ts - t0, 3.5*per);
        repeat (3) @(posedge mclk);
    endtask

    task automatic short_pulses;
        for (int k = 0; k < 6; k++) begin
            @(posedge mclk); #(real'($urandom_range(5, 60)) / 100.0 * per);
            stop_req = 1'b1;
            #(real'($urandom_range(10, 35)) / 100.0 * per);
            stop_req = 1'b0;
            repeat (5) @(posedge mclk);
        end
    endtask

    initial begin
        do_reset(1'b0, 1'b1);
        // R9: stop held through reset takes effect after release
        lat_start(0.4);
        check_period;
        for (int k = 0; k < 6; k++) begin
            lat_stop(real'($urandom_range(3, 97)) / 100.0);
            lat_start(real'($urandom_range(3, 97)) / 100.0);
        end
        short_pulses;
        // R3: held state observed at the ports
        stop_req = 1'b1;
        repeat (6) @(posedge mclk);
        #(per/4);
        chk(out_p == '0 && out_n == '1, "R3", "held pair levels", real'(out_n), real'({NP{1'b1}}));
        do_reset(1'b1, 1'b0);
        check_period;
        for (int k = 0; k < 4; k++) begin
            lat_stop(real'($urandom_range(3, 97)) / 100.0);
            lat_start(real'($urandom_range(3, 97)) / 100.0);
        end
        short_pulses;
        repeat (4) @(posedge mclk);
        done = 1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog R1 actual=timeout expected=completion");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule